// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic FIR Filter

This block computes a 16-tap FIR filter output without any hardware multiplier. Each accepted input sample enters a tap-delay line. The filter then visits the bit positions of the stored samples one per clock, starting with the least significant. At each position, the bits taken from neighbouring pairs of taps form 2-bit selects. Each select drives a small 4-way multiplexer that holds precomputed coefficient sums. An adder tree combines the multiplexer outputs into one partial sum. That partial sum is weighted by its bit position and added into a wide accumulator. At the sign position it is subtracted instead.

One output costs as many cycles as the sample has bits, whatever the number of taps. The coefficients are fixed at elaboration. A new sample is taken only while the block is idle. When the last bit position has been processed, the result is published together with a one-cycle valid pulse. The result then stays on the output until the next pulse.

Top module: `da_fir_filter`

## Requirements
- R1: While rst_ni is low, busy_o and result_valid_o are 0 and result_o is 0. All taps of the delay line are cleared to zero.
- R2: A sample is accepted only on a rising clock edge where sample_valid_i is 1 and busy_o is 0. A sample_valid_i seen while busy_o is 1 is ignored and leaves the delay line and the results unchanged.
- R3: After an accepting edge, busy_o is 1 for exactly 16 cycles. result_valid_o is 1 for exactly one cycle: the cycle after the 16th processing cycle, in which busy_o is 0 again.
- R4: Tap 0 holds the newest sample and tap k holds the sample accepted k acceptances earlier. result_o equals the sum over k of coef[k]*tap[k], taken modulo 2^34 as a two's-complement value whose bit 33 is the sign.
- R5: For each tap pair (2p, 2p+1), the select {bit of tap 2p+1, bit of tap 2p} picks one of four values: 0 for 00, coef[2p] for 01, coef[2p+1] for 10, and coef[2p]+coef[2p+1] for 11. A single impulse of value 1 therefore produces the coefficients in tap order on successive outputs.
- R6: Samples are two's complement. The most negative sample -32768 and the largest positive sample 32767 give exact results, because the sign bit position is weighted by -2^15.
- R7: result_o changes only in a cycle where result_valid_o is 1, and holds its value otherwise.
- R8: If sample_valid_i stays high, a new sample is accepted in the same cycle that result_valid_o is 1. This gives one output every 17 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 16 | Two's-complement input sample |
| sample_valid_i | input | 1 | Sample offered this cycle |
| busy_o | output | 1 | Bit-serial computation in progress; samples are not accepted |
| result_o | output | 34 | Filter output, two's complement |
| result_valid_o | output | 1 | One-cycle pulse marking a new result |

## Verification
The hardest case to reach from the ports is the sign position combined with extreme values in many taps at once. It shows up only when every one of the 16 taps holds -32768 or 32767 and the coefficients include -32768. The stimulus reaches it by streaming runs of the extremes through the full delay line with a coefficient set that contains both extremes. A behavioural convolution over the sample history predicts each result. A second case is a sample offered while busy: the bench asserts sample_valid_i with garbage in the middle of a computation. It then confirms that the later outputs still match a history that leaves that sample out.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;
  localparam int TAPS  = 16;
  localparam int DW    = 16;
  localparam int CW    = 16;
  localparam int ACC_W = 34;

  typedef logic signed [CW-1:0] coef_t;

  localparam coef_t DEF_COEF [TAPS] = '{
    -16'sd120, -16'sd310, 16'sd0,    16'sd812,
     16'sd1650, 16'sd2970, 16'sd4410, 16'sd5380,
     16'sd5380, 16'sd4410, 16'sd2970, 16'sd1650,
     16'sd812,  16'sd0,   -16'sd310, -16'sd120
  };
endpackage

// File: rtl/da_delay_line.sv
module da_delay_line #(
  parameter int TAPS = 16,
  parameter int DW   = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] taps_o [TAPS]
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < TAPS; k++) taps_o[k] <= '0;
    end else if (shift_i) begin
      taps_o[0] <= din_i;
      for (int k = 1; k < TAPS; k++) taps_o[k] <= taps_o[k-1];
    end
  end

  // R4
  shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> taps_o[0] == $past(din_i));
endmodule

// File: rtl/da_pair_mux.sv
module da_pair_mux #(
  parameter int CW = 16,
  parameter logic signed [CW-1:0] CA = '0,
  parameter logic signed [CW-1:0] CB = '0
) (
  input  logic [1:0]         sel_i,
  output logic signed [CW:0] val_o
);
  localparam logic signed [CW:0] EA = {CA[CW-1], CA};
  localparam logic signed [CW:0] EB = {CB[CW-1], CB};
  localparam logic signed [CW:0] EAB = EA + EB;

  always_comb begin
    unique case (sel_i)
      2'b00:   val_o = '0;
      2'b01:   val_o = EA;
      2'b10:   val_o = EB;
      default: val_o = EAB;
    endcase
  end
endmodule

// File: rtl/da_bit_slice.sv
module da_bit_slice #(
  parameter int TAPS = 16,
  parameter int CW   = 16,
  parameter logic signed [CW-1:0] COEF [TAPS] = '{default: '0},
  localparam int PAIRS = TAPS / 2,
  localparam int PS_W  = CW + $clog2(TAPS)
) (
  input  logic [TAPS-1:0]          bits_i,
  output logic signed [PS_W-1:0]   ps_o
);
  logic signed [CW:0] mux_s [PAIRS];

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    da_pair_mux #(.CW(CW), .CA(COEF[2*p]), .CB(COEF[2*p+1])) u_mux (
      .sel_i ({bits_i[2*p+1], bits_i[2*p]}),
      .val_o (mux_s[p])
    );
  end

  always_comb begin
    ps_o = '0;
    for (int p = 0; p < PAIRS; p++)
      ps_o = ps_o + PS_W'(mux_s[p]);
  end
endmodule

// File: rtl/da_shift_acc.sv
module da_shift_acc #(
  parameter int PS_W  = 20,
  parameter int ACC_W = 34,
  parameter int DW    = 16,
  localparam int SH_W = $clog2(DW)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    first_i,
  input  logic                    last_i,
  input  logic [SH_W-1:0]         shamt_i,
  input  logic signed [PS_W-1:0]  ps_i,
  output logic signed [ACC_W-1:0] acc_next_o
);
  logic signed [ACC_W-1:0] acc_q, ps_ext, weighted;

  assign ps_ext   = {{(ACC_W-PS_W){ps_i[PS_W-1]}}, ps_i};
  assign weighted = ps_ext <<< shamt_i;

  always_comb begin
    if (first_i)     acc_next_o = weighted;
    else if (last_i) acc_next_o = acc_q - weighted; // sign position weighs -2^(DW-1)
    else             acc_next_o = acc_q + weighted;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= acc_next_o;
  end
endmodule

// File: rtl/da_fir_filter.sv
module da_fir_filter #(
  parameter int TAPS  = da_fir_pkg::TAPS,
  parameter int DW    = da_fir_pkg::DW,
  parameter int CW    = da_fir_pkg::CW,
  parameter int ACC_W = da_fir_pkg::ACC_W,
  parameter logic signed [CW-1:0] COEF [TAPS] = da_fir_pkg::DEF_COEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DW-1:0]    sample_i,
  input  logic             sample_valid_i,
  output logic             busy_o,
  output logic [ACC_W-1:0] result_o,
  output logic             result_valid_o
);
  localparam int SH_W = $clog2(DW);
  localparam int PS_W = CW + $clog2(TAPS);

  logic                    busy_q, valid_q, accept_s, last_s;
  logic [SH_W-1:0]         bit_q;
  logic [DW-1:0]           taps_s [TAPS];
  logic [TAPS-1:0]         bits_s;
  logic signed [PS_W-1:0]  ps_s;
  logic signed [ACC_W-1:0] acc_next_s;
  logic [ACC_W-1:0]        res_q;

  assign accept_s = sample_valid_i & ~busy_q;
  assign last_s   = (bit_q == SH_W'(DW-1));

  da_delay_line #(.TAPS(TAPS), .DW(DW)) u_dly (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (accept_s),
    .din_i   (sample_i),
    .taps_o  (taps_s)
  );

  always_comb begin
    for (int k = 0; k < TAPS; k++) bits_s[k] = taps_s[k][bit_q];
  end

  da_bit_slice #(.TAPS(TAPS), .CW(CW), .COEF(COEF)) u_slice (
    .bits_i (bits_s),
    .ps_o   (ps_s)
  );

  da_shift_acc #(.PS_W(PS_W), .ACC_W(ACC_W), .DW(DW)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (busy_q),
    .first_i    (bit_q == '0),
    .last_i     (last_s),
    .shamt_i    (bit_q),
    .ps_i       (ps_s),
    .acc_next_o (acc_next_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      bit_q   <= '0;
      res_q   <= '0;
    end else begin
      valid_q <= 1'b0;
      if (busy_q) begin
        if (last_s) begin
          busy_q  <= 1'b0;
          valid_q <= 1'b1;
          res_q   <= acc_next_s;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end else if (accept_s) begin
        busy_q <= 1'b1;
        bit_q  <= '0;
      end
    end
  end

  assign busy_o         = busy_q;
  assign result_o       = res_q;
  assign result_valid_o = valid_q;

  // R3
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o);
  // R3
  busy_valid_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && result_valid_o));
  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> result_valid_o);
  // R2
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && sample_valid_i) |=> $stable(taps_s[0]));
  // R7
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> result_valid_o);
endmodule

// File: tb/sim_da_fir_filter.sv
`timescale 1ns/1ps
module sim_da_fir_filter;
  localparam int TAPS = 16;
  localparam logic signed [15:0] TB_COEF [TAPS] = '{
    -16'sd32768, 16'sd32767, 16'sd1, -16'sd1,
     16'sd12345, -16'sd2222, 16'sd0, 16'sd700,
    -16'sd9000,  16'sd4096, 16'sd31000, -16'sd17,
     16'sd5,    -16'sd30000, 16'sd256, 16'sd77
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] sample_i = '0;
  logic        sample_valid_i = 1'b0;
  logic        busy_o, result_valid_o;
  logic [33:0] result_o;

  int checks = 0, failures = 0, cycles = 0;
  string cur_req = "R4";

  always #4 clk_i = ~clk_i;

  da_fir_filter #(.COEF(TB_COEF)) u0 (
    .clk_i, .rst_ni, .sample_i, .sample_valid_i,
    .busy_o, .result_o, .result_valid_o
  );

  // behavioural reference
  int     hist [TAPS];
  bit     m_busy, m_valid;
  int     m_cnt;
  longint m_pend;
  logic [33:0] m_res;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < TAPS; k++) hist[k] = 0;
      m_busy = 0; m_valid = 0; m_cnt = 0; m_pend = 0; m_res = '0;
    end else begin
      m_valid = 0;
      if (m_busy) begin
        if (m_cnt == 15) begin
          m_busy = 0; m_valid = 1; m_res = m_pend[33:0];
        end else m_cnt++;
      end else if (sample_valid_i) begin
        for (int k = TAPS-1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = int'($signed(sample_i));
        m_pend = 0;
        for (int k = 0; k < TAPS; k++)
          m_pend += longint'(TB_COEF[k]) * longint'(hist[k]);
        m_busy = 1; m_cnt = 0;
      end
    end
  end

  always @(negedge clk_i) begin
    cycles++;
    if (rst_ni) begin
      checks++;
      if (busy_o !== m_busy || result_valid_o !== m_valid) begin
        failures++;
        $display("FAIL R3 busy/valid act=%b/%b exp=%b/%b", busy_o, result_valid_o, m_busy, m_valid);
      end
      checks++;
      if (result_o !== m_res) begin
        failures++;
        if (m_valid)
          $display("FAIL %s result act=%0d exp=%0d", cur_req, $signed(result_o), $signed(m_res));
        else
          $display("FAIL R7 held result act=%0d exp=%0d", $signed(result_o), $signed(m_res));
      end
    end
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp<=100000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic send(input logic [15:0] x);
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    sample_i = x; sample_valid_i = 1'b1;
    @(negedge clk_i);
    sample_valid_i = 1'b0;
  endtask

  task automatic stream(input logic [15:0] x);
    sample_i = x; sample_valid_i = 1'b1;
    forever begin
      if (!busy_o) begin @(negedge clk_i); break; end
      @(negedge clk_i);
    end
  endtask

  task automatic drain();
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    checks++;
    if (busy_o !== 1'b0 || result_valid_o !== 1'b0 || result_o !== '0) begin
      failures++;
      $display("FAIL R1 reset act=%b/%b/%0d exp=0/0/0", busy_o, result_valid_o, result_o);
    end
    rst_ni = 1'b1;

    // R5: impulse walks coefficients out in tap order (R1: cleared history)
    cur_req = "R5";
    send(16'd1);
    for (int i = 1; i < TAPS + 2; i++) send(16'd0);
    drain();

    // R2: offers while busy are ignored
    cur_req = "R2";
    send(16'd1234);
    repeat (4) @(negedge clk_i);
    sample_i = 16'hBEEF; sample_valid_i = 1'b1;
    @(negedge clk_i);
    sample_valid_i = 1'b0;
    send(16'd777);
    repeat (5) @(negedge clk_i);
    sample_i = 16'h8001; sample_valid_i = 1'b1;
    repeat (3) @(negedge clk_i);
    sample_valid_i = 1'b0;
    drain();

    // R6: extremes filling every tap
    cur_req = "R6";
    for (int i = 0; i < TAPS + 2; i++) send(16'h8000);
    for (int i = 0; i < TAPS + 2; i++) send(16'h7FFF);
    for (int i = 0; i < 20; i++) send(i[0] ? 16'h8000 : 16'h7FFF);
    drain();

    // R8: back-to-back with sample_valid_i held high
    cur_req = "R8";
    @(negedge clk_i);
    for (int i = 0; i < 24; i++) stream(16'($urandom));
    sample_valid_i = 1'b0;
    drain();

    // R4: random history
    cur_req = "R4";
    for (int i = 0; i < 60; i++) send(16'($urandom));
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule